// File: doc/BRIEF.md
# Operand-Wakeup Issue Queue

This block is the scheduling buffer that sits in front of a single functional unit in an out-of-order core. Every functional unit owns one such queue. Dispatch writes renamed instructions into it in program order. Each instruction carries two source tags, a destination tag and an opcode payload. The queue holds an instruction until both of its operands are known to be produced, and then offers it to the unit.

Operand readiness is learned by watching the shared result bus. Whenever a producer completes, the bus carries the tag of the new value. Every occupied slot compares its waiting source tags with that tag and marks matching operands ready. Each cycle the queue offers exactly one instruction whose operands are all ready. When several are ready it offers the one that arrived first, so a younger independent instruction can overtake an older one that is still waiting. A full flag throttles dispatch, and a flush input empties the queue.

Top module: `issue_queue_wakeup`

## Requirements
- R1: After reset the queue is empty: `iss_valid` and `full` are both 0.
- R2: An instruction whose two source tags are both 0 (the hardwired zero register, always ready) is offered on `iss_valid`/`iss_op`/`iss_dst` in the cycle after the dispatch edge.
- R3: An instruction with nonzero source tags is not offered until a result-bus broadcast has carried each of those tags. It is offered in the cycle after the edge that captured the last of them.
- R4: A broadcast on the same edge as the dispatch of an instruction that waits on that tag marks the operand ready, so the instruction is offered in the next cycle.
- R5: When several entries are ready together, the one dispatched earliest is offered. This holds even when slots have been reused.
- R6: A younger ready instruction is offered ahead of an older instruction that is still waiting on an operand.
- R7: `full` is 1 exactly when all DEPTH entries are occupied. It falls in the cycle after an offered instruction is accepted (`iss_valid` and `iss_ready` both 1 at an edge). Dispatch must not be asserted while `full` is 1.
- R8: An offered instruction that is not accepted stays in the queue, and `iss_valid` stays 1.
- R9: On the cycle after `flush` is sampled high, every entry is invalid: `iss_valid` is 0 and `full` is 0. Flushed instructions are never offered afterwards.
- R10: A broadcast whose tag matches no waiting source leaves every entry waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| disp_valid | input | 1 | Dispatch writes an instruction this cycle |
| disp_src1 | input | TAG_W | First source tag (0 = always ready) |
| disp_src2 | input | TAG_W | Second source tag (0 = always ready) |
| disp_dst | input | TAG_W | Destination tag |
| disp_op | input | OP_W | Opcode payload |
| full | output | 1 | No free entry |
| cdb_valid | input | 1 | Result-bus broadcast present |
| cdb_tag | input | TAG_W | Tag of the produced result |
| iss_valid | output | 1 | An instruction is offered to the unit |
| iss_ready | input | 1 | Unit accepts the offered instruction |
| iss_src1 | output | TAG_W | First source tag of offered instruction |
| iss_src2 | output | TAG_W | Second source tag of offered instruction |
| iss_dst | output | TAG_W | Destination tag of offered instruction |
| iss_op | output | OP_W | Opcode payload of offered instruction |

## Verification
The assertions assume that dispatch never writes while `full` is high. They also assume that a single accepted issue is the only way an entry leaves, apart from flush. The bench therefore issues each dispatch only after it has seen `full` low. It drives `iss_ready` for whole cycles from its own tasks, and it sends at most one broadcast per cycle. Expected issue order is pushed into a scoreboard before the unit is allowed to accept. Any instruction that is reordered, dropped or offered after a flush then shows up as a mismatch.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEF_DEPTH = 4;
  localparam int unsigned IQ_DEF_TAG_W = 6;
  localparam int unsigned IQ_DEF_OP_W  = 16;

  // per-slot status bits
  typedef struct packed {
    logic busy;
    logic rdy_a;
    logic rdy_b;
  } iq_flags_t;
endpackage

// File: rtl/iq_slot.sv
module iq_slot import iq_pkg::*; #(
  parameter int unsigned TAG_W = IQ_DEF_TAG_W,
  parameter int unsigned OP_W  = IQ_DEF_OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_src1,
  input  logic [TAG_W-1:0] wr_src2,
  input  logic [TAG_W-1:0] wr_dst,
  input  logic [OP_W-1:0]  wr_op,
  input  logic             release_en,
  input  logic             bus_valid,
  input  logic [TAG_W-1:0] bus_tag,
  output logic             occupied,
  output logic             can_go,
  output logic [TAG_W-1:0] src1,
  output logic [TAG_W-1:0] src2,
  output logic [TAG_W-1:0] dst,
  output logic [OP_W-1:0]  op
);
  iq_flags_t st;
  logic new_a, new_b, hit_a, hit_b;

  // readiness of an operand arriving this cycle
  assign new_a = (wr_src1 == '0) || (bus_valid && bus_tag == wr_src1);
  assign new_b = (wr_src2 == '0) || (bus_valid && bus_tag == wr_src2);
  // wakeup of a held operand
  assign hit_a = bus_valid && (bus_tag == src1);
  assign hit_b = bus_valid && (bus_tag == src2);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st <= '0;
    end else if (wr_en) begin
      st.busy  <= 1'b1;
      st.rdy_a <= new_a;
      st.rdy_b <= new_b;
    end else begin
      if (release_en) st.busy <= 1'b0;
      if (hit_a) st.rdy_a <= 1'b1;
      if (hit_b) st.rdy_b <= 1'b1;
    end
  end

  // payload: written only on allocation, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      src1 <= wr_src1;
      src2 <= wr_src2;
      dst  <= wr_dst;
      op   <= wr_op;
    end
  end

  assign occupied = st.busy;
  assign can_go   = st.busy & st.rdy_a & st.rdy_b;
endmodule

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] busy,
  output logic [IDX_W-1:0] slot,
  output logic             any_free
);
  always_comb begin
    slot     = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        slot     = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_age_arb.sv
module iq_age_arb #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_slot,
  input  logic [DEPTH-1:0] req,
  output logic [DEPTH-1:0] grant
);
  // ahead[j][i] = 1 when slot j was written before slot i
  logic [DEPTH-1:0] ahead [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) ahead[j] <= '0;
    end else if (alloc_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (IDX_W'(j) == alloc_slot) ahead[j] <= '0;
        else ahead[j][alloc_slot] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    logic [DEPTH-1:0] blockers;
    always_comb begin
      for (int j = 0; j < DEPTH; j++) blockers[j] = req[j] & ahead[j][i];
    end
    assign grant[i] = req[i] & ~(|blockers);
  end
endmodule

// File: rtl/issue_queue_wakeup.sv
module issue_queue_wakeup import iq_pkg::*; #(
  parameter int unsigned DEPTH = IQ_DEF_DEPTH,
  parameter int unsigned TAG_W = IQ_DEF_TAG_W,
  parameter int unsigned OP_W  = IQ_DEF_OP_W,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_src1,
  input  logic [TAG_W-1:0] disp_src2,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic [OP_W-1:0]  disp_op,
  output logic             full,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [TAG_W-1:0] iss_src1,
  output logic [TAG_W-1:0] iss_src2,
  output logic [TAG_W-1:0] iss_dst,
  output logic [OP_W-1:0]  iss_op
);
  logic [DEPTH-1:0] busy, rdy, grant, wr_vec, rel_vec;
  logic [IDX_W-1:0] free_slot;
  logic             any_free, do_alloc;
  logic [TAG_W-1:0] s1 [DEPTH];
  logic [TAG_W-1:0] s2 [DEPTH];
  logic [TAG_W-1:0] dd [DEPTH];
  logic [OP_W-1:0]  oo [DEPTH];

  assign do_alloc = disp_valid & any_free & ~flush;

  iq_free_pick #(.DEPTH(DEPTH)) u_free (
    .busy(busy), .slot(free_slot), .any_free(any_free)
  );

  iq_age_arb #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst(rst), .alloc_en(do_alloc), .alloc_slot(free_slot),
    .req(rdy), .grant(grant)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign wr_vec[k]  = do_alloc && (free_slot == IDX_W'(k));
    assign rel_vec[k] = grant[k] & iss_ready;
    iq_slot #(.TAG_W(TAG_W), .OP_W(OP_W)) u_slot (
      .clk(clk), .rst(rst), .flush(flush),
      .wr_en(wr_vec[k]), .wr_src1(disp_src1), .wr_src2(disp_src2),
      .wr_dst(disp_dst), .wr_op(disp_op),
      .release_en(rel_vec[k]), .bus_valid(cdb_valid), .bus_tag(cdb_tag),
      .occupied(busy[k]), .can_go(rdy[k]),
      .src1(s1[k]), .src2(s2[k]), .dst(dd[k]), .op(oo[k])
    );
  end

  // one-hot grant -> AND-OR payload mux
  always_comb begin
    iss_src1 = '0;
    iss_src2 = '0;
    iss_dst  = '0;
    iss_op   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      iss_src1 |= s1[k] & {TAG_W{grant[k]}};
      iss_src2 |= s2[k] & {TAG_W{grant[k]}};
      iss_dst  |= dd[k] & {TAG_W{grant[k]}};
      iss_op   |= oo[k] & {OP_W{grant[k]}};
    end
  end

  assign iss_valid = |grant;
  assign full      = ~any_free;
endmodule

// File: rtl/iq_wakeup_chk.sv
module iq_wakeup_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic clk,
  input logic rst,
  input logic flush,
  input logic disp_valid,
  input logic full,
  input logic iss_valid,
  input logic iss_ready
);
  logic [CNT_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst || flush) occ <= '0;
    else occ <= occ + CNT_W'(disp_valid && !full) - CNT_W'(iss_valid && iss_ready);
  end

  assert_no_dispatch_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    full |-> !disp_valid);
  assert_full_matches_occupancy_R7: assert property (@(posedge clk) disable iff (rst)
    full == (occ == CNT_W'(DEPTH)));
  assert_empty_offers_nothing_R1: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !iss_valid);
  assert_offer_held_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready && !flush) |=> iss_valid);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!iss_valid && !full));
endmodule

bind issue_queue_wakeup iq_wakeup_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid),
  .full(full), .iss_valid(iss_valid), .iss_ready(iss_ready)
);

// File: tb/sim_issue_queue_wakeup.sv
`timescale 1ns/1ps
module sim_issue_queue_wakeup;
  localparam int DEPTH = 4;
  localparam int TAG_W = 6;
  localparam int OP_W  = 16;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic disp_valid = 1'b0;
  logic [TAG_W-1:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
  logic [OP_W-1:0]  disp_op = '0;
  logic full, cdb_valid = 1'b0, iss_valid, iss_ready = 1'b0;
  logic [TAG_W-1:0] cdb_tag = '0, iss_src1, iss_src2, iss_dst;
  logic [OP_W-1:0]  iss_op;

  int checks = 0, failures = 0;
  logic [OP_W-1:0] exp_q [$];

  always #10 clk = ~clk;

  issue_queue_wakeup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid),
    .disp_src1(disp_src1), .disp_src2(disp_src2), .disp_dst(disp_dst),
    .disp_op(disp_op), .full(full), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_src1(iss_src1),
    .iss_src2(iss_src2), .iss_dst(iss_dst), .iss_op(iss_op)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic disp(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b,
                      input logic [OP_W-1:0] op);
    disp_valid = 1'b1;
    disp_src1  = a;
    disp_src2  = b;
    disp_dst   = TAG_W'(op[5:0]);
    disp_op    = op;
    step();
    disp_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t);
    cdb_valid = 1'b1;
    cdb_tag   = t;
    step();
    cdb_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    iss_ready = 1'b1;
    repeat (n) step();
    iss_ready = 1'b0;
  endtask

  // scoreboard monitor: compare every accepted issue
  always @(negedge clk) begin
    if (!rst && iss_valid && iss_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected issue actual=%0h expected=none", iss_op);
      end else begin
        logic [OP_W-1:0] e;
        e = exp_q.pop_front();
        if (iss_op !== e) begin
          failures++;
          $display("FAIL R5/R6 issue order actual=%0h expected=%0h", iss_op, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 iss_valid", 32'(iss_valid), 32'd0);
    check("R1 full", 32'(full), 32'd0);

    // R2: zero sources are ready
    disp(0, 0, 16'h0011);
    check("R2 iss_valid", 32'(iss_valid), 32'd1);
    check("R2 iss_op", 32'(iss_op), 32'h0011);
    check("R2 iss_dst", 32'(iss_dst), 32'h11);
    exp_q.push_back(16'h0011);
    drain(1);
    check("R2 drained", 32'(iss_valid), 32'd0);

    // R3 / R10: wait on two tags
    disp(5, 7, 16'h0022);
    check("R3 waits", 32'(iss_valid), 32'd0);
    bcast(9);
    check("R10 foreign tag", 32'(iss_valid), 32'd0);
    bcast(5);
    check("R3 one of two", 32'(iss_valid), 32'd0);
    bcast(7);
    check("R3 woken", 32'(iss_valid), 32'd1);
    check("R3 iss_src2", 32'(iss_src2), 32'd7);
    exp_q.push_back(16'h0022);
    drain(1);

    // R4: broadcast on dispatch edge
    cdb_valid = 1'b1;
    cdb_tag   = 6'd3;
    disp(3, 0, 16'h0033);
    cdb_valid = 1'b0;
    check("R4 same-cycle capture", 32'(iss_valid), 32'd1);
    exp_q.push_back(16'h0033);
    drain(1);

    // R6: younger ready overtakes older waiting
    disp(12, 0, 16'h0041);
    disp(0, 0, 16'h0042);
    check("R6 younger offered", 32'(iss_op), 32'h0042);
    exp_q.push_back(16'h0042);
    drain(1);
    check("R6 older still waits", 32'(iss_valid), 32'd0);
    bcast(12);
    exp_q.push_back(16'h0041);
    drain(1);

    // R5: oldest among simultaneously ready
    disp(20, 0, 16'h0051);
    disp(0, 0, 16'h0052);
    disp(0, 0, 16'h0053);
    check("R5 before wake", 32'(iss_op), 32'h0052);
    bcast(20);
    check("R5 oldest ready", 32'(iss_op), 32'h0051);
    exp_q.push_back(16'h0051);
    exp_q.push_back(16'h0052);
    exp_q.push_back(16'h0053);
    drain(3);

    // R7 / R8: fill, hold, free one, reuse slot
    for (int i = 1; i <= DEPTH; i++) disp(0, 0, 16'(16'h0060 + i));
    check("R7 full", 32'(full), 32'd1);
    repeat (3) step();
    check("R8 held valid", 32'(iss_valid), 32'd1);
    check("R8 held op", 32'(iss_op), 32'h0061);
    exp_q.push_back(16'h0061);
    drain(1);
    check("R7 full drops", 32'(full), 32'd0);
    disp(0, 0, 16'h0065);
    check("R7 full again", 32'(full), 32'd1);
    exp_q.push_back(16'h0062);
    exp_q.push_back(16'h0063);
    exp_q.push_back(16'h0064);
    exp_q.push_back(16'h0065);
    drain(4);
    check("R7 empty", 32'(full), 32'd0);

    // R9: flush
    disp(0, 0, 16'h0070);
    disp(30, 0, 16'h0072);
    flush = 1'b1;
    step();
    flush = 1'b0;
    check("R9 iss_valid", 32'(iss_valid), 32'd0);
    check("R9 full", 32'(full), 32'd0);
    bcast(30);
    check("R9 no revival", 32'(iss_valid), 32'd0);
    disp(0, 0, 16'h0071);
    exp_q.push_back(16'h0071);
    drain(2);
    check("R9 scoreboard empty", 32'(exp_q.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule